// File: doc/BRIEF.md
# Banked Address Decoder and Shared-Bus Arbiter

This block sits between a processor and a set of memories and register windows. It splits a 24-bit address space into 256 banks of 64 KB, using the top eight address bits as the bank number. For each processor access it picks exactly one target: chip RAM, slow RAM, fast RAM, a real-time-clock window, a custom-register window, or nothing. It then presents a target-relative offset to the memory side. A runtime layout bit selects between an early map and a late map. The two maps place the clock window in different banks and differ in whether a second bank mirrors the custom registers. Reads of unmapped space return zeros, ones, or whatever value the bus last carried.

Chip RAM, custom registers and (unless delays are disabled) slow RAM share one bus with DMA. A processor access to those targets therefore waits for a cycle in which the DMA-busy input is low. Fast RAM, the clock window and unmapped space complete without waiting. A separate combinational path maps DMA addresses. It can place the upper half of a 1 MB chip range onto slow RAM when the enhanced-chipset mirror is enabled and both RAMs are 512 KB.

The processor side is a request/ready handshake. A request is accepted in the idle state and moves to the issue state. From there it either completes at once or passes to the stall state, where it stays until the shared bus is free. Transitions: IDLE to ISSUE on request. ISSUE to IDLE on completion. ISSUE to STALL when a shared target meets DMA activity. STALL to IDLE on the first DMA-free cycle.

Top module: `bus_bank_arbiter`

## Requirements
- R1: Banks 0x00 to 0x1F select chip RAM (mem_sel code 1). The offset is the address modulo the installed size: chip size code 0 gives 256 KB, code 1 gives 512 KB, and codes 2 and 3 give 1 MB.
- R2: Fast RAM (code 3) occupies banks from 0x20 up to, but not including, 0x20 + 32 × fast size code. Code 0 means no fast RAM. The offset is the address minus 0x200000.
- R3: Slow RAM (code 2) occupies banks from 0xC0 up to, but not including, 0xC0 + 8 × slow size code. The offset is the address minus 0xC00000.
- R4: With cfg_late_map = 1 the clock window (code 4) is bank 0xDC. With cfg_late_map = 0 it is bank 0xD8, and bank 0xDC mirrors the custom registers (code 5). Bank 0xDF is custom in both maps. Both windows give the offset as address bits 15:0.
- R5: An access to any other bank has mem_sel code 0 and raises no mem_go. A read returns 0x0000 for unmapped mode 0 and 0xFFFF for mode 1. For modes 2 and 3 it returns the last value the bus carried: the data of the last completed write, or the data of the last completed read. That value is 0x0000 after reset.
- R6: After reset cpu_ready and mem_go are low. A request is accepted only in the idle state. cpu_ready is high for exactly one cycle per access, at the earliest in the cycle after acceptance.
- R7: An access to chip RAM, custom registers, or slow RAM with cfg_no_slow_delay = 0 completes in the first cycle after acceptance in which dma_busy is low. It therefore waits one extra cycle for each busy cycle.
- R8: An access to fast RAM, the clock window, unmapped space, or slow RAM with cfg_no_slow_delay = 1 completes in the first cycle after acceptance whatever dma_busy is.
- R9: dma_hit is high only when dma_req is high and the DMA address lies in banks 0x00 to 0x1F. Without the mirror the DMA offset wraps like R1.
- R10: When cfg_enhanced, cfg_mirror_en, chip size code 1 and slow size code 1 all hold, DMA addresses 0x080000 to 0x0FFFFF give dma_to_slow = 1 with the offset equal to the address minus 0x080000. In every other case dma_to_slow is 0 and the mirror setting has no effect.
- R11: mem_go pulses together with cpu_ready for mapped targets. It carries mem_sel, mem_addr (the offset), mem_we and mem_wdata. A read returns mem_rdata in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_late_map | input | 1 | 1 selects the late map, 0 the early map |
| cfg_chip_size | input | 2 | Chip RAM size code |
| cfg_slow_size | input | 2 | Slow RAM size code, in 512 KB steps |
| cfg_fast_size | input | 2 | Fast RAM size code, in 2 MB steps |
| cfg_unmapped | input | 2 | Unmapped read value mode |
| cfg_enhanced | input | 1 | Enhanced chipset present |
| cfg_mirror_en | input | 1 | Slow-to-chip DMA mirror requested |
| cfg_no_slow_delay | input | 1 | Slow RAM skips the DMA wait |
| dma_busy | input | 1 | Shared bus used by DMA this cycle |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | Write when high |
| cpu_addr | input | 24 | Processor byte address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 16 | Read data, valid with cpu_ready |
| mem_go | output | 1 | Access strobe to the selected target |
| mem_we | output | 1 | Write flag to target |
| mem_sel | output | 3 | Target code |
| mem_addr | output | 24 | Offset within the target |
| mem_wdata | output | 16 | Write data to target |
| mem_rdata | input | 16 | Read data from target |
| dma_req | input | 1 | DMA access request |
| dma_addr | input | 24 | DMA address |
| dma_hit | output | 1 | DMA address reaches RAM |
| dma_to_slow | output | 1 | DMA access goes to slow RAM |
| dma_offset | output | 24 | Offset within the DMA target |

## Verification
A wrongly latched decode shows up at once in the completing cycle, as a wrong mem_sel or mem_addr, or as a read value that does not match the target. A wrong FSM state shows up as a shift in ready timing. A stall state that misses the free slot delays cpu_ready by one or more cycles beyond the count of busy cycles. An issue state that ignores DMA completes a chip access while dma_busy is high. A corrupted bus latch is only visible on the next floating-mode unmapped read, which may come many accesses later. The bench therefore mixes such reads into random traffic.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int unsigned ADDR_W = 24;
    localparam int unsigned DATA_W = 16;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_CHIP   = 3'd1,
        TGT_SLOW   = 3'd2,
        TGT_FAST   = 3'd3,
        TGT_RTC    = 3'd4,
        TGT_CUSTOM = 3'd5
    } target_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_STALL = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        UM_ZERO  = 2'd0,
        UM_ONES  = 2'd1,
        UM_FLOAT = 2'd2,
        UM_HOLD  = 2'd3
    } unmapped_e;

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder
    import bank_pkg::*;
#(
    parameter int unsigned AW          = ADDR_W,
    parameter int unsigned CHIP_BITS0  = 18,
    parameter logic [7:0]  CHIP_TOP    = 8'h1F,
    parameter logic [7:0]  FAST_BASE   = 8'h20,
    parameter int unsigned FAST_STEP   = 32,
    parameter logic [7:0]  SLOW_BASE   = 8'hC0,
    parameter int unsigned SLOW_STEP   = 8,
    parameter logic [7:0]  CLK_EARLY   = 8'hD8,
    parameter logic [7:0]  CLK_LATE    = 8'hDC,
    parameter logic [7:0]  CUSTOM_BANK = 8'hDF
) (
    input  logic [AW-1:0] addr,
    input  logic          late_map,
    input  logic [1:0]    chip_size,
    input  logic [1:0]    slow_size,
    input  logic [1:0]    fast_size,
    input  logic          no_slow_delay,
    output target_e       tgt,
    output logic [AW-1:0] offset,
    output logic          shared
);

    localparam int unsigned BANK_LSB = AW - 8;
    localparam logic [AW-1:0] FAST_ORG = {FAST_BASE, {BANK_LSB{1'b0}}};
    localparam logic [AW-1:0] SLOW_ORG = {SLOW_BASE, {BANK_LSB{1'b0}}};

    logic [7:0]    bank;
    logic [8:0]    fast_end;
    logic [8:0]    slow_end;
    logic [7:0]    clk_bank;
    logic [AW-1:0] chip_mask;

    always_comb begin
        bank     = addr[AW-1:BANK_LSB];
        fast_end = {1'b0, FAST_BASE} + 9'(FAST_STEP) * {7'd0, fast_size};
        slow_end = {1'b0, SLOW_BASE} + 9'(SLOW_STEP) * {7'd0, slow_size};
        clk_bank = late_map ? CLK_LATE : CLK_EARLY;
        unique case (chip_size)
            2'd0:    chip_mask = (AW'(1) << CHIP_BITS0) - AW'(1);
            2'd1:    chip_mask = (AW'(1) << (CHIP_BITS0 + 1)) - AW'(1);
            default: chip_mask = (AW'(1) << (CHIP_BITS0 + 2)) - AW'(1);
        endcase
    end

    always_comb begin
        tgt    = TGT_NONE;
        offset = '0;
        if (bank <= CHIP_TOP) begin
            tgt    = TGT_CHIP;
            offset = addr & chip_mask;
        end else if (bank >= FAST_BASE && {1'b0, bank} < fast_end) begin
            tgt    = TGT_FAST;
            offset = addr - FAST_ORG;
        end else if (bank >= SLOW_BASE && {1'b0, bank} < slow_end) begin
            tgt    = TGT_SLOW;
            offset = addr - SLOW_ORG;
        end else if (bank == clk_bank) begin
            tgt    = TGT_RTC;
            offset = {{(AW-BANK_LSB){1'b0}}, addr[BANK_LSB-1:0]};
        end else if (bank == CUSTOM_BANK || (!late_map && bank == CLK_LATE)) begin
            tgt    = TGT_CUSTOM;
            offset = {{(AW-BANK_LSB){1'b0}}, addr[BANK_LSB-1:0]};
        end
    end

    always_comb begin
        unique case (tgt)
            TGT_CHIP, TGT_CUSTOM: shared = 1'b1;
            TGT_SLOW:             shared = !no_slow_delay;
            default:              shared = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_mapper.sv
module dma_mapper
    import bank_pkg::*;
#(
    parameter int unsigned AW         = ADDR_W,
    parameter int unsigned CHIP_BITS0 = 18
) (
    input  logic          dma_req,
    input  logic [AW-1:0] dma_addr,
    input  logic [1:0]    chip_size,
    input  logic [1:0]    slow_size,
    input  logic          enhanced,
    input  logic          mirror_en,
    output logic          hit,
    output logic          to_slow,
    output logic [AW-1:0] offset
);

    localparam int unsigned HALF_BITS = CHIP_BITS0 + 1;
    localparam int unsigned REGION_BITS = CHIP_BITS0 + 3;

    logic          in_chip;
    logic          mirror_on;
    logic          upper_half;
    logic [AW-1:0] wrap_mask;

    always_comb begin
        in_chip    = (dma_addr >> REGION_BITS) == '0;
        mirror_on  = enhanced && mirror_en && chip_size == 2'd1 && slow_size == 2'd1;
        upper_half = (dma_addr >> HALF_BITS) == AW'(1);
        unique case (chip_size)
            2'd0:    wrap_mask = (AW'(1) << CHIP_BITS0) - AW'(1);
            2'd1:    wrap_mask = (AW'(1) << HALF_BITS) - AW'(1);
            default: wrap_mask = (AW'(1) << (CHIP_BITS0 + 2)) - AW'(1);
        endcase
    end

    always_comb begin
        hit     = dma_req && in_chip;
        to_slow = hit && mirror_on && upper_half;
        if (to_slow) offset = dma_addr & ((AW'(1) << HALF_BITS) - AW'(1));
        else         offset = dma_addr & wrap_mask;
    end

endmodule

// File: rtl/cpu_bus_fsm.sv
module cpu_bus_fsm
    import bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic dma_busy,
    input  logic pend_shared,
    output logic accept,
    output logic complete
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cpu_req) begin
                    accept  = 1'b1;
                    state_d = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (pend_shared && dma_busy) begin
                    state_d = S_STALL;
                end else begin
                    complete = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            S_STALL: begin
                if (!dma_busy) begin
                    complete = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

endmodule

// File: rtl/bus_bank_arbiter.sv
module bus_bank_arbiter
    import bank_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_late_map,
    input  logic [1:0]    cfg_chip_size,
    input  logic [1:0]    cfg_slow_size,
    input  logic [1:0]    cfg_fast_size,
    input  logic [1:0]    cfg_unmapped,
    input  logic          cfg_enhanced,
    input  logic          cfg_mirror_en,
    input  logic          cfg_no_slow_delay,
    input  logic          dma_busy,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_go,
    output logic          mem_we,
    output logic [2:0]    mem_sel,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dma_req,
    input  logic [AW-1:0] dma_addr,
    output logic          dma_hit,
    output logic          dma_to_slow,
    output logic [AW-1:0] dma_offset
);

    target_e       dec_tgt;
    logic [AW-1:0] dec_off;
    logic          dec_shared;

    target_e       p_tgt;
    logic [AW-1:0] p_off;
    logic          p_shared;
    logic          p_we;
    logic [DW-1:0] p_wdata;
    logic [DW-1:0] bus_last;
    logic [DW-1:0] ret_data;

    logic accept;
    logic complete;

    bank_decoder #(.AW(AW)) u_dec (
        .addr          (cpu_addr),
        .late_map      (cfg_late_map),
        .chip_size     (cfg_chip_size),
        .slow_size     (cfg_slow_size),
        .fast_size     (cfg_fast_size),
        .no_slow_delay (cfg_no_slow_delay),
        .tgt           (dec_tgt),
        .offset        (dec_off),
        .shared        (dec_shared)
    );

    cpu_bus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .dma_busy    (dma_busy),
        .pend_shared (p_shared),
        .accept      (accept),
        .complete    (complete)
    );

    dma_mapper #(.AW(AW)) u_dma (
        .dma_req   (dma_req),
        .dma_addr  (dma_addr),
        .chip_size (cfg_chip_size),
        .slow_size (cfg_slow_size),
        .enhanced  (cfg_enhanced),
        .mirror_en (cfg_mirror_en),
        .hit       (dma_hit),
        .to_slow   (dma_to_slow),
        .offset    (dma_offset)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_tgt    <= TGT_NONE;
            p_off    <= '0;
            p_shared <= 1'b0;
            p_we     <= 1'b0;
            p_wdata  <= '0;
        end else if (accept) begin
            p_tgt    <= dec_tgt;
            p_off    <= dec_off;
            p_shared <= dec_shared;
            p_we     <= cpu_we;
            p_wdata  <= cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        bus_last <= '0;
        else if (complete) bus_last <= p_we ? p_wdata : ret_data;
    end

    always_comb begin
        if (p_tgt != TGT_NONE) begin
            ret_data = mem_rdata;
        end else begin
            unique case (unmapped_e'(cfg_unmapped))
                UM_ZERO:           ret_data = '0;
                UM_ONES:           ret_data = '1;
                UM_FLOAT, UM_HOLD: ret_data = bus_last;
                default:           ret_data = bus_last;
            endcase
        end
    end

    always_comb begin
        cpu_ready = complete;
        cpu_rdata = complete ? ret_data : '0;
        mem_go    = complete && (p_tgt != TGT_NONE);
        mem_we    = p_we;
        mem_sel   = p_tgt;
        mem_addr  = p_off;
        mem_wdata = p_wdata;
    end

endmodule

// File: rtl/bus_bank_arbiter_chk.sv
module bus_bank_arbiter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_chip_size,
    input logic [1:0]  cfg_slow_size,
    input logic        cfg_enhanced,
    input logic        cfg_mirror_en,
    input logic        cfg_no_slow_delay,
    input logic        dma_busy,
    input logic        cpu_req,
    input logic        cpu_ready,
    input logic        mem_go,
    input logic [2:0]  mem_sel,
    input logic [23:0] dma_addr,
    input logic        dma_hit,
    input logic        dma_to_slow
);

    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_ready_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> $past(cpu_req));

    assert_go_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_go |-> (cpu_ready && mem_sel != 3'd0));

    assert_unmapped_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && mem_sel == 3'd0) |-> !mem_go);

    assert_shared_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && dma_busy) |->
            !(mem_sel == 3'd1 || mem_sel == 3'd5 || (mem_sel == 3'd2 && !cfg_no_slow_delay)));

    assert_dma_chip_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_hit |-> (dma_addr < 24'h200000));

    assert_mirror_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_to_slow |-> (cfg_enhanced && cfg_mirror_en && cfg_chip_size == 2'd1
                         && cfg_slow_size == 2'd1 && dma_hit));

endmodule

bind bus_bank_arbiter bus_bank_arbiter_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_chip_size     (cfg_chip_size),
    .cfg_slow_size     (cfg_slow_size),
    .cfg_enhanced      (cfg_enhanced),
    .cfg_mirror_en     (cfg_mirror_en),
    .cfg_no_slow_delay (cfg_no_slow_delay),
    .dma_busy          (dma_busy),
    .cpu_req           (cpu_req),
    .cpu_ready         (cpu_ready),
    .mem_go            (mem_go),
    .mem_sel           (mem_sel),
    .dma_addr          (dma_addr),
    .dma_hit           (dma_hit),
    .dma_to_slow       (dma_to_slow)
);

// File: tb/bus_bank_arbiter_tb.sv
module bus_bank_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_late_map = 1'b0;
    logic [1:0]  cfg_chip_size = 2'd1;
    logic [1:0]  cfg_slow_size = 2'd1;
    logic [1:0]  cfg_fast_size = 2'd0;
    logic [1:0]  cfg_unmapped = 2'd0;
    logic        cfg_enhanced = 1'b0;
    logic        cfg_mirror_en = 1'b0;
    logic        cfg_no_slow_delay = 1'b0;
    logic        dma_busy = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        mem_go;
    logic        mem_we;
    logic [2:0]  mem_sel;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        dma_req = 1'b0;
    logic [23:0] dma_addr = '0;
    logic        dma_hit;
    logic        dma_to_slow;
    logic [23:0] dma_offset;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] last_bus = '0;

    always #4 clk = ~clk;

    assign mem_rdata = mem_addr[15:0] ^ 16'hA5C3 ^ {13'd0, mem_sel};

    bus_bank_arbiter u_dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [26:0] model(input logic [23:0] a);
        logic [7:0]  b;
        logic [23:0] m;
        b = a[23:16];
        m = (cfg_chip_size == 0) ? 24'h03FFFF : (cfg_chip_size == 1) ? 24'h07FFFF : 24'h0FFFFF;
        if (b <= 8'h1F) return {3'd1, a & m};
        if (int'(b) >= 32 && int'(b) < 32 + 32 * int'(cfg_fast_size)) return {3'd3, a - 24'h200000};
        if (int'(b) >= 192 && int'(b) < 192 + 8 * int'(cfg_slow_size)) return {3'd2, a - 24'hC00000};
        if (b == (cfg_late_map ? 8'hDC : 8'hD8)) return {3'd4, 8'h00, a[15:0]};
        if (b == 8'hDF || (!cfg_late_map && b == 8'hDC)) return {3'd5, 8'h00, a[15:0]};
        return 27'd0;
    endfunction

    function automatic string tag_of(input logic [2:0] t);
        case (t)
            3'd1: return "R1";
            3'd2: return "R3";
            3'd3: return "R2";
            3'd0: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic access(input logic [23:0] a, input logic we, input logic [15:0] wd, input int busy);
        logic [26:0] m;
        logic [2:0]  t;
        logic        sh;
        logic [15:0] expd;
        int k;
        m  = model(a);
        t  = m[26:24];
        sh = (t == 3'd1) || (t == 3'd5) || (t == 3'd2 && !cfg_no_slow_delay);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; dma_busy = 1'b0;
        @(posedge clk);
        k = 0;
        forever begin
            @(negedge clk);
            dma_busy = (k < busy);
            #1;
            if (cpu_ready) break;
            k++;
            if (k > 40) break;
        end
        check(sh ? "R7 wait" : "R8 wait", k, sh ? busy : 0);
        check("R11 go", mem_go, t != 3'd0);
        check({tag_of(t), " sel"}, mem_sel, t);
        if (t != 3'd0) begin
            check({tag_of(t), " offset"}, mem_addr, m[23:0]);
            check("R11 we", mem_we, we);
            if (we) check("R11 wdata", mem_wdata, wd);
        end
        if (!we) begin
            if (t != 3'd0) expd = m[15:0] ^ 16'hA5C3 ^ {13'd0, t};
            else if (cfg_unmapped == 2'd0) expd = 16'h0000;
            else if (cfg_unmapped == 2'd1) expd = 16'hFFFF;
            else expd = last_bus;
            check({tag_of(t), " rdata"}, cpu_rdata, expd);
            last_bus = expd;
        end else begin
            last_bus = wd;
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0; dma_busy = 1'b0;
        @(negedge clk);
        check("R6 single ready", cpu_ready, 0);
    endtask

    task automatic dma_chk(input logic [23:0] a, input logic rq, input logic eh,
                           input logic es, input logic [23:0] eo, input string tag);
        @(negedge clk);
        dma_req = rq; dma_addr = a;
        #1;
        check({tag, " hit"}, dma_hit, eh);
        check({tag, " slow"}, dma_to_slow, es);
        if (eh) check({tag, " offset"}, dma_offset, eo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R6 reset ready", cpu_ready, 0);
        check("R6 reset go", mem_go, 0);

        // R5: floating read right after reset returns zero
        cfg_unmapped = 2'd2;
        access(24'hE01234, 1'b0, 16'h0, 0);
        // R5: write to unmapped then floating read returns written value
        access(24'hE40000, 1'b1, 16'h1234, 0);
        access(24'hF00002, 1'b0, 16'h0, 2);
        cfg_unmapped = 2'd1;
        access(24'hE00000, 1'b0, 16'h0, 0);

        // R4: layout variants
        cfg_late_map = 1'b0;
        access(24'hDC0010, 1'b0, 16'h0, 1);
        access(24'hD80020, 1'b0, 16'h0, 2);
        cfg_late_map = 1'b1;
        access(24'hDC0030, 1'b0, 16'h0, 2);
        access(24'hD80040, 1'b0, 16'h0, 0);
        access(24'hDF0050, 1'b1, 16'hBEEF, 3);

        // R1: chip wrap; R7 stalls
        cfg_chip_size = 2'd0;
        access(24'h0C5678, 1'b0, 16'h0, 3);
        cfg_chip_size = 2'd2;
        access(24'h1F0002, 1'b1, 16'h5555, 1);

        // R2/R8: fast ignores DMA
        cfg_fast_size = 2'd3;
        access(24'h7FFFFE, 1'b0, 16'h0, 3);
        access(24'h800000, 1'b0, 16'h0, 0);

        // R3: slow with and without bus delay
        cfg_slow_size = 2'd3;
        access(24'hD7FFF0, 1'b0, 16'h0, 2);
        cfg_no_slow_delay = 1'b1;
        access(24'hC12340, 1'b0, 16'h0, 2);
        cfg_no_slow_delay = 1'b0;

        // R9/R10 directed DMA mapping
        cfg_chip_size = 2'd1; cfg_slow_size = 2'd1;
        cfg_enhanced = 1'b0; cfg_mirror_en = 1'b1;
        dma_chk(24'h0A1234, 1'b1, 1'b1, 1'b0, 24'h021234, "R10 no enhanced");
        cfg_enhanced = 1'b1;
        dma_chk(24'h0A1234, 1'b1, 1'b1, 1'b1, 24'h021234, "R10 mirror");
        dma_chk(24'h0FFFFE, 1'b1, 1'b1, 1'b1, 24'h07FFFE, "R10 mirror top");
        dma_chk(24'h07FFFE, 1'b1, 1'b1, 1'b0, 24'h07FFFE, "R10 lower half");
        cfg_chip_size = 2'd2;
        dma_chk(24'h0A1234, 1'b1, 1'b1, 1'b0, 24'h0A1234, "R10 chip 1M");
        cfg_chip_size = 2'd0;
        dma_chk(24'h050000, 1'b1, 1'b1, 1'b0, 24'h010000, "R9 wrap");
        dma_chk(24'h200000, 1'b1, 1'b0, 1'b0, 24'h0, "R9 outside");
        dma_chk(24'h001000, 1'b0, 1'b0, 1'b0, 24'h0, "R9 no req");

        // random traffic
        for (int i = 0; i < 160; i++) begin
            logic [7:0]  bk;
            logic [23:0] a;
            int sel;
            cfg_late_map      = 1'($urandom % 2);
            cfg_chip_size     = 2'($urandom % 4);
            cfg_slow_size     = 2'($urandom % 4);
            cfg_fast_size     = 2'($urandom % 4);
            cfg_unmapped      = 2'($urandom % 4);
            cfg_no_slow_delay = 1'($urandom % 2);
            sel = int'($urandom % 8);
            case (sel)
                0: bk = 8'($urandom % 32);
                1: bk = 8'(32 + $urandom % 128);
                2: bk = 8'(192 + $urandom % 24);
                3: bk = 8'hD8;
                4: bk = 8'hDC;
                5: bk = 8'hDF;
                6: bk = 8'($urandom);
                default: bk = 8'(224 + $urandom % 32);
            endcase
            a = {bk, 16'($urandom)};
            access(a, 1'($urandom % 2), 16'($urandom), int'($urandom % 4));
        end

        for (int i = 0; i < 40; i++) begin
            logic [23:0] a;
            logic        mir;
            logic [23:0] wm;
            cfg_chip_size = 2'($urandom % 4);
            cfg_slow_size = 2'($urandom % 4);
            cfg_enhanced  = 1'($urandom % 2);
            cfg_mirror_en = 1'($urandom % 2);
            a = 24'($urandom % 24'h300000);
            mir = cfg_enhanced && cfg_mirror_en && cfg_chip_size == 1 && cfg_slow_size == 1
                  && a >= 24'h080000 && a < 24'h100000;
            wm = (cfg_chip_size == 0) ? 24'h03FFFF : (cfg_chip_size == 1) ? 24'h07FFFF : 24'h0FFFFF;
            dma_chk(a, 1'b1, a < 24'h200000, mir, mir ? a - 24'h080000 : a & wm, "R9 R10 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule